// File: doc/BRIEF.md
# Pipeline ADC digital corrector

This block is the digital back end of a pipelined analog-to-digital converter. It has six redundant subconverter stages and one final 2-bit flash stage. The redundant stages each resolve one of three decisions (0, 1 or 2) and run on alternating clock phases. As a result, the codes for one analog sample arrive spread over several half-periods. The block captures each stage's code on its own edge and moves the falling-edge codes onto the rising edge. It then delays every code until all of them line up with the final stage's code for the same sample.

The aligned codes are combined by overlapped addition. Each redundant code is weighted by a power of two that halves from stage to stage, and adjacent weights overlap by one bit. Because of this overlap, a comparator decision that is off by one step in an early stage is absorbed by the later stages. The sum is saturated to eight bits and presented as an offset-binary word.

A valid flag enters alongside each sample and leaves with its word at a fixed latency of six clocks. After that latency, one word follows per clock.

Top module: `pipe_adc_corrector`

## Requirements
- R1: While `rst_n` is low, `out_word` reads 0x00 and `out_vld` reads 0, whatever `smp_vld`, `stg_code` and `fin_code` carry; the reset acts without waiting for a clock edge.
- R2: After `rst_n` rises, `out_vld` stays 0 through the first six rising edges, even if `smp_vld` was held high during reset.
- R3: A sample flagged by `smp_vld` at rising edge n produces `out_vld` = 1 from rising edge n+6 for one cycle; an unflagged sample produces `out_vld` = 0 in that cycle.
- R4: Stage i (0..5) drives `stg_code[2i+1:2i]`. For sample n, an even stage is captured on rising edge n+1+i/2, and an odd stage on the falling edge half a period after rising edge n+1+(i-1)/2. `fin_code` is captured on rising edge n+4. Each stage contributes only to its own sample's word.
- R5: The word equals fin_code + the sum over i of code_i·2^(6−i), in offset binary. 0xFF is positive full scale, 0x00 is negative full scale, 0x80 is the first code above mid-scale and 0x7F is the last code below it.
- R6: With ideal stage decisions for a normalised input v in [−1, 1), the word equals floor((v+1)·128).
- R7: Comparator threshold errors of up to 1/8 of full scale in any redundant stage leave the word equal to floor((v+1)·128).
- R8: A redundant-stage code of 3 is weighted as 3. A total above 255 gives 0xFF, and totals at or below 255 pass unchanged.
- R9: Consecutive samples yield words on consecutive cycles. Unflagged samples interleaved in the stream do not alter the words of their flagged neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; both edges used for stage capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | High at the rising edge where a sample is taken |
| stg_code | input | 12 | Redundant stage codes, stage i in bits [2i+1:2i] |
| fin_code | input | 2 | Final flash stage code |
| out_word | output | 8 | Corrected offset-binary result |
| out_vld | output | 1 | Marks `out_word` as belonging to a flagged sample |

## Verification
Suppose one stage's delay line is a cycle too short or too long. That stage's weight is then taken from the neighbouring sample. The error shows up in the first flagged word after the fault, as a difference of a multiple of 2^(6−i) against the ideal quantisation. One-hot stage patterns in consecutive samples pin that difference to the offending stage. A fault in the valid chain or a missed reset of it shows within six clocks, as a flag that arrives early or late, or as a flag that appears before the pipeline has refilled. A wrong saturation shows as a word that wraps instead of sticking at 0xFF.

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
  parameter int NSTG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [2*NSTG-1:0] stg_code,
  input  logic [1:0]        fin_code,
  output logic [NSTG+1:0]   out_word,
  output logic              out_vld
);

  localparam int OUT_W = NSTG + 2;
  localparam int SUM_W = OUT_W + 1;
  localparam int ALN   = (NSTG + 1) / 2;
  localparam int LAT   = ALN + 3;

  logic [NSTG-1:0][1:0] aln;
  logic [1:0]           fin_q;
  logic [SUM_W-1:0]     sum_c;
  logic [SUM_W-1:0]     sum_q;
  logic [LAT:0]         vsr;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    localparam int D = ALN - (g + 1) / 2;
    logic [1:0] ent;

    if (g % 2 == 0) begin : g_rise
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ent <= '0;
        else        ent <= stg_code[2*g +: 2];
    end else begin : g_fall
      logic [1:0] neg_q;
      always_ff @(negedge clk or negedge rst_n)
        if (!rst_n) neg_q <= '0;
        else        neg_q <= stg_code[2*g +: 2];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ent <= '0;
        else        ent <= neg_q;
    end

    if (D == 0) begin : g_nodly
      assign aln[g] = ent;
    end else begin : g_dly
      logic [D-1:0][1:0] dl;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dl <= '0;
        else begin
          dl[0] <= ent;
          for (int k = 1; k < D; k++) dl[k] <= dl[k-1];
        end
      assign aln[g] = dl[D-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fin_q <= '0;
    else        fin_q <= fin_code;

  always_comb begin
    sum_c = SUM_W'(fin_q);
    for (int i = 0; i < NSTG; i++)
      sum_c = sum_c + (SUM_W'(aln[i]) << (NSTG - i));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sum_q    <= '0;
      out_word <= '0;
    end else begin
      sum_q    <= sum_c;
      out_word <= sum_q[SUM_W-1] ? '1 : sum_q[OUT_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vsr <= '0;
    else        vsr <= {vsr[LAT-1:0], smp_vld};

  assign out_vld = vsr[LAT];

endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk #(
  parameter int NSTG = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_vld,
  input logic            out_vld,
  input logic [NSTG+1:0] out_word
);

  localparam int LAT = (NSTG + 1) / 2 + 3;
  localparam int CW  = $clog2(LAT + 2);

  logic [LAT:0] sh;
  logic [CW:0]  fill;
  logic [CW:0]  pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh   <= '0;
      fill <= '0;
      pend <= '0;
    end else begin
      sh   <= {sh[LAT-1:0], smp_vld};
      if (fill < (CW+1)'(LAT)) fill <= fill + 1'b1;
      pend <= pend + {{CW{1'b0}}, smp_vld} - {{CW{1'b0}}, out_vld};
    end

  // R1
  always @(negedge clk)
    if (!rst_n) reset_state_chk: assert (out_vld == 1'b0 && out_word == '0);

  // R2
  refill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill < (CW+1)'(LAT)) |-> !out_vld);

  // R3
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == sh[LAT]);

  // R3
  vld_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend <= (CW+1)'(LAT + 1)) && (out_vld -> pend != '0));

  // R5
  word_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> !$isunknown(out_word));

endmodule

bind pipe_adc_corrector adc_corr_chk #(.NSTG(NSTG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_vld  (smp_vld),
  .out_vld  (out_vld),
  .out_word (out_word)
);

// File: tb/tb_pipe_adc_corrector.sv
module tb_pipe_adc_corrector;
  localparam int NSTG = 6;
  localparam int LAT  = 6;
  localparam int MAXS = 2200;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_vld = 1'b0;
  logic [2*NSTG-1:0] stg_code = '0;
  logic [1:0]        fin_code = '0;
  logic [NSTG+1:0]   out_word;
  logic              out_vld;

  always #5 clk = ~clk;

  pipe_adc_corrector #(.NSTG(NSTG)) dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .stg_code(stg_code),
    .fin_code(fin_code), .out_word(out_word), .out_vld(out_vld)
  );

  int    code_a [MAXS][NSTG+1];
  bit    vld_a  [MAXS];
  int    exp_a  [MAXS];
  string tag_a  [MAXS];
  int    ns;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int getc(int n, int i);
    if (n < 0 || n >= ns) return 0;
    return code_a[n][i];
  endfunction

  function automatic bit getv(int n);
    if (n < 0 || n >= ns) return 1'b0;
    return vld_a[n];
  endfunction

  // ideal 1.5-bit stage model on a 2048-step input grid, v = x/1024
  function automatic void add_ideal(int x, bit offs, bit v, string tag);
    int r = x;
    int f;
    for (int i = 0; i < NSTG; i++) begin
      int tu = 256;
      int tl = -256;
      int d;
      if (offs) begin
        tu += ((i * 53 + 17) % 257) - 128;
        tl += ((i * 91 + 40) % 257) - 128;
      end
      d = (r >= tu) ? 2 : ((r < tl) ? 0 : 1);
      code_a[ns][i] = d;
      r = 2 * r - (d - 1) * 1024;
    end
    f = (r + 1024) >>> 9;
    if (f > 3) f = 3;
    code_a[ns][NSTG] = f;
    exp_a[ns] = (x + 1024) >>> 3;
    vld_a[ns] = v;
    tag_a[ns] = tag;
    ns++;
  endfunction

  function automatic void add_raw(int c [NSTG+1], string tag);
    int s = c[NSTG];
    for (int i = 0; i < NSTG; i++) begin
      code_a[ns][i] = c[i];
      s += c[i] << (NSTG - i);
    end
    code_a[ns][NSTG] = c[NSTG];
    exp_a[ns] = (s > 255) ? 255 : s;
    vld_a[ns] = 1'b1;
    tag_a[ns] = tag;
    ns++;
  endfunction

  task automatic drive_odd(int m);
    for (int i = 1; i < NSTG; i += 2)
      stg_code[2*i +: 2] = 2'(getc(m - 1 - (i - 1) / 2, i));
  endtask

  task automatic drive_even(int m);
    for (int i = 0; i < NSTG; i += 2)
      stg_code[2*i +: 2] = 2'(getc(m - i / 2, i));
    fin_code = 2'(getc(m - NSTG / 2, NSTG));
    smp_vld  = getv(m + 1);
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n    = 1'b0;
    smp_vld  = 1'b1;
    stg_code = {NSTG{2'b10}};
    fin_code = 2'd3;
    repeat (3) begin
      @(negedge clk); #1;
      chk("R1", int'(out_vld), 0);
      chk("R1", int'(out_word), 0);
    end
    rst_n = 1'b1;
    drive_odd(-1);
    drive_even(-1);
  endtask

  task automatic run(string vtag);
    for (int m = 0; m < ns + LAT + 4; m++) begin
      int n;
      bit ev;
      @(posedge clk); #1;
      drive_odd(m);
      @(negedge clk); #1;
      n  = m - LAT;
      ev = getv(n);
      chk((m < LAT) ? "R2" : vtag, int'(out_vld), int'(ev));
      if (ev) chk(tag_a[n], int'(out_word), exp_a[n]);
      drive_even(m);
    end
  endtask

  initial begin
    ns = 0;
    for (int x = -1024; x < 1024; x++) add_ideal(x, 1'b0, 1'b1, "R6");
    do_reset();
    run("R3");

    ns = 0;
    for (int x = -1024; x < 1024; x++) add_ideal(x, 1'b1, (((x + 1024) % 5) != 3), "R7");
    do_reset();
    run("R9");

    ns = 0;
    add_raw('{0, 0, 0, 0, 0, 0, 0}, "R5");
    add_raw('{2, 2, 2, 2, 2, 2, 3}, "R5");
    add_raw('{1, 1, 1, 1, 1, 1, 2}, "R5");
    add_raw('{1, 1, 1, 1, 1, 1, 1}, "R5");
    for (int i = 0; i < NSTG; i++) begin
      int c [NSTG+1];
      c = '{default: 0};
      c[i] = 1;
      add_raw(c, "R4");
      c[i] = 2;
      c[NSTG] = 3;
      add_raw(c, "R4");
    end
    add_raw('{3, 2, 2, 2, 2, 2, 3}, "R8");
    add_raw('{3, 0, 0, 0, 0, 0, 0}, "R8");
    add_raw('{3, 3, 3, 3, 3, 3, 3}, "R8");
    add_raw('{1, 1, 1, 1, 1, 3, 2}, "R8");
    add_raw('{2, 3, 2, 2, 2, 2, 3}, "R8");
    add_raw('{1, 3, 0, 3, 0, 3, 1}, "R8");
    do_reset();
    run("R3");

    finish_run();
  end
endmodule